// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This block is the timing heart of a two-stage watchdog. It runs on a reference clock, and one clock cycle is one reference tick. A start or keep-alive loads a scaled stage-one timeout. When that timeout runs out, the block sends a one-cycle interrupt pulse and begins the stage-two timeout. If stage two also runs out, the block can raise a system reset request and record that fact in a sticky flag. In free-run mode it starts stage one again instead.

A neighbouring register block supplies the preloads, the mode bits and single-cycle command pulses. Bus decoding and any unlock key handling sit in that neighbour, not here. The flag keeps its value through the warm reset `rst`. Only the clear command or the cold reset `rst_por` clears it, so software can find out after a reboot that the watchdog caused it.

Top module: `wdt_two_stage`

## Requirements
- R1: After `rst_por`, or after `rst` held for at least one clock, `running`, `stage_two`, `irq_pulse`, `smi_pulse` and `reset_req` are 0. `rst_por` also clears `prev_reboot`.
- R2: A stage loaded from preload P lasts L reference cycles. L = P·2^5 when `scale_fast`=1 and P·2^15 when `scale_fast`=0. The first interrupt pulse is visible on the cycle after the L-th clock edge that follows the edge on which the start was registered.
- R3: At the end of stage one, exactly one one-cycle pulse appears: on `irq_pulse` when `int_to_smi`=0, or on `smi_pulse` when `int_to_smi`=1. In the same cycle `stage_two` becomes 1 and a countdown from `preload_two` begins.
- R4: When stage two ends with `reboot_en`=1, `reset_req` pulses for one cycle and `prev_reboot` is set in the same cycle. The core then stops with `running`=0 and `stage_two`=0. This takes priority over free-run.
- R5: When stage two ends with `reboot_en`=0 and `free_run`=1, stage one is reloaded at once. The next interrupt pulse comes L2+L1 cycles after the previous one.
- R6: When stage two ends with `reboot_en`=0 and `free_run`=0, the core stops with `running`=0 and `stage_two`=0. It gives no reset request and leaves the flag unchanged.
- R7: A rising edge of `wd_enable`, or a `kick` pulse while `wd_enable`=1, restarts the count at stage one from either stage.
- R8: A `kick` while `wd_enable`=0 is ignored: `running` stays 0 and no pulse appears.
- R9: Dropping `wd_enable` stops the count on the next edge. No pulse follows until the core is started again.
- R10: A `kick` registered on the same edge as an expiry wins: no expiry pulse appears, and stage one restarts with its full length.
- R11: `prev_reboot` holds through `rst` and is cleared by a `flag_clear` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per cycle |
| rst | input | 1 | Synchronous warm reset, active high; keeps the flag |
| rst_por | input | 1 | Synchronous cold reset, active high; clears everything |
| wd_enable | input | 1 | Watchdog enable level |
| free_run | input | 1 | Restart stage one after a stage-two expiry when reboot is off |
| reboot_en | input | 1 | Request a system reset at the end of stage two |
| scale_fast | input | 1 | 1: scale by 2^5; 0: scale by 2^15 |
| int_to_smi | input | 1 | Stage-one pulse goes to `smi_pulse` when 1, to `irq_pulse` when 0 |
| preload_one | input | PRE_W | Stage-one preload |
| preload_two | input | PRE_W | Stage-two preload |
| kick | input | 1 | Keep-alive pulse |
| flag_clear | input | 1 | Clears the previous-reboot flag |
| irq_pulse | output | 1 | Stage-one interrupt pulse, interrupt line |
| smi_pulse | output | 1 | Stage-one interrupt pulse, management line |
| reset_req | output | 1 | One-cycle system reset request |
| prev_reboot | output | 1 | Sticky flag: a watchdog reset happened |
| running | output | 1 | A countdown is active |
| stage_two | output | 1 | 1 while stage two counts, 0 otherwise |

## Verification
The assertions assume only that one of the two resets is applied before the first check. They also assume that `kick` and `flag_clear` are single-cycle pulses, although nothing breaks if they are held longer. The stimulus changes mode bits and preloads only while `wd_enable` is low, drives every input on the falling edge, and keeps preloads small in the 2^5 scale. This keeps each run to a few hundred cycles, so a single long run is enough to cover the 2^15 scale.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WS_STOPPED = 2'd0,
        WS_FIRST   = 2'd1,
        WS_SECOND  = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic load;
        logic pick_two;
        logic halt;
        logic fire_int;
        logic fire_rst;
    } wdt_act_t;

    function automatic logic [63:0] scale_ticks(input logic [31:0] pre,
                                                input logic        fast,
                                                input int unsigned sh_fast,
                                                input int unsigned sh_slow);
        logic [63:0] wide;
        wide = {32'd0, pre};
        return fast ? (wide << sh_fast) : (wide << sh_slow);
    endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int PRE_W   = 20,
    parameter int SH_FAST = 5,
    parameter int SH_SLOW = 15,
    parameter int CNT_W   = PRE_W + SH_SLOW
) (
    input  logic             clk,
    input  logic             rst,
    input  wdt_act_t         act,
    input  logic             live,
    input  logic             fast,
    input  logic [PRE_W-1:0] pre_one,
    input  logic [PRE_W-1:0] pre_two,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [PRE_W-1:0] pre_sel;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        pre_sel  = act.pick_two ? pre_two : pre_one;
        load_val = CNT_W'(scale_ticks(32'(pre_sel), fast, SH_FAST, SH_SLOW));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (act.halt)
            cnt <= '0;
        else if (act.load)
            cnt <= load_val;
        else if (live && cnt != '0)
            cnt <= cnt - ONE;
    end

    assign expire = live && (cnt <= ONE);

    // R2: a free-running stage loses exactly one tick per cycle
    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        (live && !act.load && !act.halt && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     kick,
    input  logic     free_run,
    input  logic     reboot_en,
    input  logic     int_smi,
    input  logic     expire,
    output wdt_act_t act,
    output logic     live,
    output logic     in_two,
    output logic     irq_o,
    output logic     smi_o,
    output logic     rst_req_o
);
    wdt_state_e state, state_d;
    logic       en_q;
    logic       start;

    assign start = en && (!en_q || kick);

    always_comb begin
        act     = '0;
        state_d = state;
        if (!en) begin
            act.halt = 1'b1;
            state_d  = WS_STOPPED;
        end else if (start) begin
            act.load = 1'b1;
            state_d  = WS_FIRST;
        end else if (expire) begin
            case (state)
                WS_FIRST: begin
                    act.load     = 1'b1;
                    act.pick_two = 1'b1;
                    act.fire_int = 1'b1;
                    state_d      = WS_SECOND;
                end
                WS_SECOND: begin
                    if (reboot_en) begin
                        act.fire_rst = 1'b1;
                        act.halt     = 1'b1;
                        state_d      = WS_STOPPED;
                    end else if (free_run) begin
                        act.load = 1'b1;
                        state_d  = WS_FIRST;
                    end else begin
                        act.halt = 1'b1;
                        state_d  = WS_STOPPED;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WS_STOPPED;
            en_q      <= 1'b0;
            irq_o     <= 1'b0;
            smi_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            state     <= state_d;
            en_q      <= en;
            irq_o     <= act.fire_int && !int_smi;
            smi_o     <= act.fire_int && int_smi;
            rst_req_o <= act.fire_rst;
        end
    end

    assign live   = (state != WS_STOPPED);
    assign in_two = (state == WS_SECOND);

    // R3: only one interrupt line per expiry, one cycle wide, and stage two follows
    a_r3_one_line: assert property (@(posedge clk) disable iff (rst) !(irq_o && smi_o));
    a_r3_irq_single: assert property (@(posedge clk) disable iff (rst) irq_o |=> !irq_o);
    a_r3_smi_single: assert property (@(posedge clk) disable iff (rst) smi_o |=> !smi_o);
    a_r3_enter_two: assert property (@(posedge clk) disable iff (rst)
        (irq_o || smi_o) |-> (state == WS_SECOND));
    // R4: reset request is one cycle and leaves the core stopped
    a_r4_req_single: assert property (@(posedge clk) disable iff (rst) rst_req_o |=> !rst_req_o);
    a_r4_req_stops: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> (state == WS_STOPPED));
    // R9: disabling halts on the next edge
    a_r9_halt: assert property (@(posedge clk) disable iff (rst) !en |=> (state == WS_STOPPED));
    // R8: with enable low nothing fires, kick or not
    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(irq_o || smi_o || rst_req_o));

endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
    input  logic clk,
    input  logic por,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (por)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R11: the flag only falls on a clear command
    a_r11_sticky: assert property (@(posedge clk) disable iff (por)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int PRE_W   = 20,
    parameter int SH_FAST = 5,
    parameter int SH_SLOW = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_por,
    input  logic             wd_enable,
    input  logic             free_run,
    input  logic             reboot_en,
    input  logic             scale_fast,
    input  logic             int_to_smi,
    input  logic [PRE_W-1:0] preload_one,
    input  logic [PRE_W-1:0] preload_two,
    input  logic             kick,
    input  logic             flag_clear,
    output logic             irq_pulse,
    output logic             smi_pulse,
    output logic             reset_req,
    output logic             prev_reboot,
    output logic             running,
    output logic             stage_two
);
    localparam int CNT_W = PRE_W + SH_SLOW;

    logic     core_rst;
    logic     expire;
    wdt_act_t act;

    assign core_rst = rst || rst_por;

    wdt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (core_rst),
        .en        (wd_enable),
        .kick      (kick),
        .free_run  (free_run),
        .reboot_en (reboot_en),
        .int_smi   (int_to_smi),
        .expire    (expire),
        .act       (act),
        .live      (running),
        .in_two    (stage_two),
        .irq_o     (irq_pulse),
        .smi_o     (smi_pulse),
        .rst_req_o (reset_req)
    );

    wdt_counter #(
        .PRE_W   (PRE_W),
        .SH_FAST (SH_FAST),
        .SH_SLOW (SH_SLOW),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (core_rst),
        .act     (act),
        .live    (running),
        .fast    (scale_fast),
        .pre_one (preload_one),
        .pre_two (preload_two),
        .expire  (expire)
    );

    wdt_flag u_flag (
        .clk  (clk),
        .por  (rst_por),
        .set  (act.fire_rst),
        .clr  (flag_clear),
        .flag (prev_reboot)
    );

    // R4: every reset request is accompanied by the flag
    a_r4_flag_with_req: assert property (@(posedge clk) disable iff (core_rst)
        reset_req |-> prev_reboot);

endmodule

// File: tb/test_wdt_two_stage.sv
module test_wdt_two_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b0, rst_por = 1'b0;
    logic        wd_enable = 1'b0, free_run = 1'b0, reboot_en = 1'b0;
    logic        scale_fast = 1'b0, int_to_smi = 1'b0, kick = 1'b0, flag_clear = 1'b0;
    logic [19:0] preload_one = '0, preload_two = '0;
    logic        irq_pulse, smi_pulse, reset_req, prev_reboot, running, stage_two;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wdt_two_stage i_wdt_two_stage (
        .clk(clk), .rst(rst), .rst_por(rst_por), .wd_enable(wd_enable),
        .free_run(free_run), .reboot_en(reboot_en), .scale_fast(scale_fast),
        .int_to_smi(int_to_smi), .preload_one(preload_one), .preload_two(preload_two),
        .kick(kick), .flag_clear(flag_clear), .irq_pulse(irq_pulse), .smi_pulse(smi_pulse),
        .reset_req(reset_req), .prev_reboot(prev_reboot), .running(running),
        .stage_two(stage_two)
    );

    function automatic int ticks(input int p, input bit fast);
        return fast ? (p * 32) : (p * 32768);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // sel 0: any interrupt pulse, 1: reset request, 2: running low
    task automatic wait_for(input int sel, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            tick();
            n++;
            if (sel == 0 && (irq_pulse || smi_pulse)) break;
            if (sel == 1 && reset_req) break;
            if (sel == 2 && !running) break;
        end
    endtask

    task automatic setup(input int p1, input int p2, input bit fast, input bit smi,
                         input bit reb, input bit fr);
        wd_enable   = 1'b0;
        tick();
        preload_one = 20'(p1);
        preload_two = 20'(p2);
        scale_fast  = fast;
        int_to_smi  = smi;
        reboot_en   = reb;
        free_run    = fr;
        tick();
    endtask

    task automatic pulse_clear();
        flag_clear = 1'b1;
        tick();
        flag_clear = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        bit quiet;
        void'($urandom(32'h1a2b3c4d));

        // R1: cold reset state
        rst_por = 1'b1;
        tick(); tick();
        rst_por = 1'b0;
        check(!running && !stage_two && !irq_pulse && !smi_pulse && !reset_req,
              "R1", "outputs idle after cold reset", {running, stage_two, reset_req}, 0);
        check(!prev_reboot, "R1", "flag after cold reset", prev_reboot, 0);

        // R2 slow scale, R3 irq line, R6 quiet stop
        setup(1, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        wd_enable = 1'b1;
        wait_for(0, 40000, n);
        check(n == ticks(1, 0) + 1, "R2", "slow stage-one length", n, ticks(1, 0) + 1);
        check(irq_pulse && !smi_pulse, "R3", "irq line chosen", smi_pulse, 0);
        check(stage_two, "R3", "stage two entered", stage_two, 1);
        tick();
        check(!irq_pulse, "R3", "pulse one cycle", irq_pulse, 0);
        wait_for(2, 40000, n);
        check(n == ticks(1, 0) - 1, "R6", "stop after stage two", n, ticks(1, 0) - 1);
        check(!stage_two && !prev_reboot, "R6", "stopped without reboot", prev_reboot, 0);

        // R4 reboot with smi line, R11 flag across warm reset
        setup(2, 3, 1'b1, 1'b1, 1'b1, 1'b0);
        wd_enable = 1'b1;
        wait_for(0, 1000, n);
        check(n == ticks(2, 1) + 1, "R2", "fast stage-one length", n, ticks(2, 1) + 1);
        check(smi_pulse && !irq_pulse, "R3", "smi line chosen", irq_pulse, 0);
        wait_for(1, 1000, n);
        check(n == ticks(3, 1), "R4", "stage-two length", n, ticks(3, 1));
        check(prev_reboot && !running && !stage_two, "R4", "flag set and stopped",
              {prev_reboot, running, stage_two}, 3'b100);
        tick();
        check(!reset_req, "R4", "request one cycle", reset_req, 0);
        wd_enable = 1'b0;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        check(prev_reboot, "R11", "flag survives warm reset", prev_reboot, 1);
        check(!running && !stage_two, "R1", "idle after warm reset", running, 0);
        pulse_clear();
        check(!prev_reboot, "R11", "flag cleared by command", prev_reboot, 0);

        // R5 free-run
        setup(1, 2, 1'b1, 1'b0, 1'b0, 1'b1);
        wd_enable = 1'b1;
        wait_for(0, 1000, n);
        wait_for(0, 1000, n);
        check(n == ticks(2, 1) + ticks(1, 1), "R5", "free-run period", n,
              ticks(2, 1) + ticks(1, 1));

        // R7 kick during stage two restarts at stage one
        setup(2, 4, 1'b1, 1'b0, 1'b0, 1'b0);
        wd_enable = 1'b1;
        wait_for(0, 1000, n);
        tick(); tick(); tick();
        kick = 1'b1;
        tick();
        kick = 1'b0;
        check(running && !stage_two, "R7", "kick returns to stage one", stage_two, 0);
        wait_for(0, 1000, n);
        check(n == ticks(2, 1), "R7", "full stage one after kick", n, ticks(2, 1));

        // R10 kick on the expiry edge wins
        setup(2, 4, 1'b1, 1'b0, 1'b0, 1'b0);
        wd_enable = 1'b1;
        repeat (ticks(2, 1)) tick();
        kick = 1'b1;
        tick();
        kick = 1'b0;
        check(!irq_pulse && !stage_two && running, "R10", "no expiry on kick edge",
              {irq_pulse, stage_two}, 0);
        wait_for(0, 1000, n);
        check(n == ticks(2, 1), "R10", "restart after collision", n, ticks(2, 1));

        // R8 kick while disabled
        setup(1, 1, 1'b1, 1'b0, 1'b0, 1'b0);
        quiet = 1'b1;
        kick = 1'b1;
        tick();
        kick = 1'b0;
        for (int i = 0; i < 150; i++) begin
            tick();
            if (running || irq_pulse || smi_pulse) quiet = 1'b0;
        end
        check(quiet, "R8", "kick ignored while disabled", quiet, 1);

        // R9 disable stops at once
        setup(1, 1, 1'b1, 1'b0, 1'b1, 1'b0);
        wd_enable = 1'b1;
        repeat (10) tick();
        wd_enable = 1'b0;
        tick();
        check(!running, "R9", "running drops next edge", running, 0);
        quiet = 1'b1;
        for (int i = 0; i < 150; i++) begin
            tick();
            if (irq_pulse || smi_pulse || reset_req) quiet = 1'b0;
        end
        check(quiet && !prev_reboot, "R9", "no pulse after disable", quiet, 1);

        // constrained random runs over modes
        for (int it = 0; it < 12; it++) begin
            int p1, p2, mode, exp;
            bit smi;
            p1   = 1 + int'($urandom % 5);
            p2   = 1 + int'($urandom % 5);
            smi  = 1'($urandom % 2);
            mode = int'($urandom % 4);
            setup(p1, p2, 1'b1, smi, (mode == 0 || mode == 3), (mode == 1 || mode == 3));
            pulse_clear();
            wd_enable = 1'b1;
            wait_for(0, 1000, n);
            check(n == ticks(p1, 1) + 1, "R2", "random stage-one length", n, ticks(p1, 1) + 1);
            check(smi_pulse == smi && irq_pulse == !smi, "R3", "random line select",
                  smi_pulse, smi);
            if (mode == 0 || mode == 3) begin
                wait_for(1, 1000, n);
                check(n == ticks(p2, 1), "R4", "random reboot timing", n, ticks(p2, 1));
                check(prev_reboot && !running, "R4", "random reboot stops",
                      {prev_reboot, running}, 2'b10);
            end else if (mode == 1) begin
                wait_for(0, 1000, n);
                exp = ticks(p2, 1) + ticks(p1, 1);
                check(n == exp, "R5", "random free-run period", n, exp);
            end else begin
                wait_for(2, 1000, n);
                check(n == ticks(p2, 1), "R6", "random quiet stop", n, ticks(p2, 1));
                check(!prev_reboot, "R6", "random flag untouched", prev_reboot, 0);
            end
        end

        wd_enable = 1'b0;
        tick();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule